// File: doc/BRIEF.md
# Timer/Counter with Shared Assignable Prescaler

This block is an 8-bit timer/counter paired with an 8-stage binary prescaler. The prescaler serves one of two consumers: the timer, or a watchdog tick path. A 6-bit mode register picks four things: what the timer counts (the internal instruction tick or an external pin), which pin edge is active, which consumer owns the prescaler, and a 3-bit rate code. The two consumers decode the rate code differently. The timer divides by 2^(code+1). The watchdog path divides by 2^code.

An internal 2-bit phase counter splits every instruction cycle into four oscillator periods and drives one-hot phase strobes. An external input first goes through a two-stage synchronizer and the edge-polarity select. It then passes through the prescaler, or bypasses it when the watchdog owns the prescaler. The resulting level is sampled on the second and fourth phase strobes, and the timer advances on a rising edge of that sampled level.

The block has four interfaces. Software writes the mode and counter registers through write ports. Software reads the counter and the sticky overflow flag. The watchdog supplies raw tick pulses and takes back the prescaled ticks.

Top module: `spt_timer_top`

## Requirements
- R1: After reset, `cnt_q` is 0, `ovf_flag` is 0 and `wdt_tick_out` is 0. All six mode bits are 1, which selects the external pin, the falling edge, watchdog ownership and rate code 7.
- R2: `phase_q` is one-hot. It steps bit 0, 1, 2, 3 and back to bit 0, one step per clock. The instruction tick is the cycle in which bit 3 is set.
- R3: With mode bit 5 = 0 (internal source) and bit 3 = 1 (watchdog owns the prescaler), the counter advances once per instruction tick.
- R4: When bit 3 = 0 (timer owns the prescaler), the timer advances once every 2^(code+1) source events, where code is mode bits 2:0.
- R5: When bit 3 = 1, `wdt_tick_out` pulses once every 2^code pulses of `wdt_tick_in`. When bit 3 = 0, every input pulse is passed through. In both cases the output appears one clock after the input.
- R6: With bit 5 = 1, bit 4 = 0 counts low-to-high transitions of `ext_pin` and bit 4 = 1 counts high-to-low transitions.
- R7: With bit 5 = 1 and bit 3 = 1, every active edge is counted, provided the pin stays high for at least 2 clocks and low for at least 2 clocks.
- R8: An increment from 0xFF gives 0x00 and sets `ovf_flag`. The flag stays set until the next counter write.
- R9: A counter write loads `cnt_wdata` on the next clock, clears `ovf_flag` and clears the prescaler if the timer owns it. Increments are then blocked during the next two instruction ticks.
- R10: A mode write that changes the owner or the rate code clears the prescaler count. The next prescaled tick therefore comes a full period after the write.
- R11: Apart from counter writes, `cnt_q` changes only on a clock edge that ends a cycle with phase bit 1 or phase bit 3 set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 6 | Mode data: [5] source, [4] edge, [3] owner, [2:0] rate code |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wdata | input | 8 | Counter load value |
| cnt_q | output | 8 | Current counter value |
| ovf_flag | output | 1 | Sticky overflow flag |
| ext_pin | input | 1 | External count input (asynchronous) |
| wdt_tick_in | input | 1 | Raw watchdog tick pulse |
| wdt_tick_out | output | 1 | Prescaled or passed-through watchdog tick |
| phase_q | output | 4 | One-hot phase strobes of the instruction cycle |

## Verification
The hardest situations to reach are the two-tick increment blackout after a counter write and the prescaler clear on a rate change. Both depend on where a write falls relative to the fourth phase and on how far the prescaler has already counted. The stimulus follows the `phase_q` output and counts fourth-phase strobes from the cycle after each write, so every expected count is exact. Constrained random runs mix sources, owners, rate codes, start values near wrap, and numbers of external edges. Directed cases land a rate change in the middle of a partial prescaler count.

// File: rtl/spt_pkg.sv
package spt_pkg;
  localparam int RATE_W = 3;
  localparam int PRE_W  = 1 << RATE_W;
  localparam int NPH    = 4;

  typedef struct packed {
    logic             src_ext;
    logic             edge_fall;
    logic             owner_wdt;
    logic [RATE_W-1:0] rate;
  } mode_t;

  localparam int    MODE_W   = $bits(mode_t);
  localparam mode_t MODE_RST = mode_t'({MODE_W{1'b1}});
endpackage

// File: rtl/spt_phase_gen.sv
module spt_phase_gen #(
  parameter int NPH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  output logic [NPH-1:0] ph_q,
  output logic           cyc_tick
);
  localparam int PW = $clog2(NPH);

  logic [PW-1:0] ph_r, ph_n;

  always_comb begin
    if (ph_r == PW'(NPH-1)) ph_n = '0;
    else                    ph_n = ph_r + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_r <= '0;
    else        ph_r <= ph_n;
  end

  for (genvar i = 0; i < NPH; i++) begin : g_strobe
    assign ph_q[i] = (ph_r == PW'(i));
  end

  assign cyc_tick = ph_q[NPH-1];

  AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q[NPH-1] |=> ph_q[0]); // R2
  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q[0] |=> ph_q[1]); // R2
  AST_PHASE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ph_q) && (ph_q != '0)); // R2
endmodule

// File: rtl/spt_pin_sync.sv
module spt_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic inv,
  output logic lvl,
  output logic rise
);
  logic [STAGES-1:0] sh_r, sh_n;
  logic              lvl_d_r, lvl_d_n;

  always_comb begin
    sh_n    = {sh_r[STAGES-2:0], pin};
    lvl_d_n = lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_r    <= '1;
      lvl_d_r <= 1'b0;
    end else begin
      sh_r    <= sh_n;
      lvl_d_r <= lvl_d_n;
    end
  end

  assign lvl  = sh_r[STAGES-1] ^ inv;
  assign rise = lvl & ~lvl_d_r;

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise); // R7
endmodule

// File: rtl/spt_prescaler.sv
module spt_prescaler #(
  parameter int RATE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              en,
  input  logic              owner_wdt,
  input  logic [RATE_W-1:0] rate,
  output logic              pulse,
  output logic              lvl
);
  localparam int CW = 1 << RATE_W;

  logic [CW-1:0] cnt_r, cnt_n;
  logic          lvl_r, lvl_n;
  logic [CW:0]   span_t;
  logic [CW-1:0] mask_t, mask_w, mask;
  logic          term;

  always_comb begin
    span_t = ((CW+1)'(2) << rate) - (CW+1)'(1);
    mask_t = span_t[CW-1:0];
    mask_w = (CW'(1) << rate) - CW'(1);
    mask   = owner_wdt ? mask_w : mask_t;
    term   = ((cnt_r & mask) == mask);
  end

  always_comb begin
    cnt_n = cnt_r;
    lvl_n = lvl_r;
    if (clr) begin
      cnt_n = '0;
      lvl_n = 1'b0;
    end else if (en) begin
      cnt_n = cnt_r + CW'(1);
      lvl_n = term;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_r <= '0;
      lvl_r <= 1'b0;
    end else begin
      cnt_r <= cnt_n;
      lvl_r <= lvl_n;
    end
  end

  assign pulse = en & ~clr & term;
  assign lvl   = lvl_r;

  AST_PRE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_r == '0) && !lvl_r); // R10
  AST_TMR_ODD_TERM: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && !owner_wdt) |-> cnt_r[0]); // R4
endmodule

// File: rtl/spt_count8.sv
module spt_count8 #(
  parameter int W   = 8,
  parameter int INH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  input  logic         inc,
  input  logic         tick,
  output logic [W-1:0] q,
  output logic         ovf
);
  localparam int IW = $clog2(INH + 1);

  logic [W-1:0]  cnt_r, cnt_n;
  logic          ovf_r, ovf_n;
  logic [IW-1:0] inh_r, inh_n;
  logic          inc_ok;

  assign inc_ok = inc && (inh_r == '0);

  always_comb begin
    cnt_n = cnt_r;
    ovf_n = ovf_r;
    inh_n = inh_r;
    if (we) begin
      cnt_n = wdata;
      ovf_n = 1'b0;
      inh_n = IW'(INH);
    end else begin
      if (inc_ok) begin
        cnt_n = cnt_r + W'(1);
        if (&cnt_r) ovf_n = 1'b1;
      end
      if (tick && (inh_r != '0)) inh_n = inh_r - IW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_r <= '0;
      ovf_r <= 1'b0;
      inh_r <= '0;
    end else begin
      cnt_r <= cnt_n;
      ovf_r <= ovf_n;
      inh_r <= inh_n;
    end
  end

  assign q   = cnt_r;
  assign ovf = ovf_r;

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_r && !we) |=> ovf_r); // R8
  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (!we && inc_ok && (&cnt_r)) |=> (ovf_r && (cnt_r == '0))); // R8
  AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> ((cnt_r == $past(wdata)) && !ovf_r)); // R9
  AST_INHIBIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((inh_r != '0) && !we) |=> (cnt_r == $past(cnt_r))); // R9
endmodule

// File: rtl/spt_timer_top.sv
module spt_timer_top
  import spt_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int INH_CYC     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_we,
  input  logic [MODE_W-1:0] mode_wdata,
  input  logic              cnt_we,
  input  logic [CNT_W-1:0]  cnt_wdata,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              ovf_flag,
  input  logic              ext_pin,
  input  logic              wdt_tick_in,
  output logic              wdt_tick_out,
  output logic [NPH-1:0]    phase_q
);
  localparam int PH_A = (NPH / 4) * 1;
  localparam int PH_B = (NPH / 4) * 3;

  logic [1:0] rs_r, rs_n;
  logic       rst_int_n;

  always_comb rs_n = {rs_r[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_r <= 2'b00;
    else        rs_r <= rs_n;
  end

  assign rst_int_n = rs_r[1];

  mode_t mode_r, mode_n, mode_in;
  logic  cyc_tick, pin_lvl, pin_rise;
  logic  pre_clr, pre_en, pre_pulse, pre_lvl;
  logic  strobe, sel_lvl, smp_r, smp_n;
  logic  ext_inc, int_inc, tmr_inc;
  logic  wdt_r, wdt_n;

  assign mode_in = mode_t'(mode_wdata);

  always_comb begin
    mode_n = mode_r;
    if (mode_we) mode_n = mode_in;
  end

  spt_phase_gen #(.NPH(NPH)) u_phase (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .ph_q     (phase_q),
    .cyc_tick (cyc_tick)
  );

  spt_pin_sync #(.STAGES(SYNC_STAGES)) u_pin (
    .clk   (clk),
    .rst_n (rst_int_n),
    .pin   (ext_pin),
    .inv   (mode_r.edge_fall),
    .lvl   (pin_lvl),
    .rise  (pin_rise)
  );

  always_comb begin
    pre_clr = (mode_we && ((mode_in.owner_wdt != mode_r.owner_wdt) ||
                           (mode_in.rate != mode_r.rate))) ||
              (cnt_we && !mode_r.owner_wdt);
    if (mode_r.owner_wdt)    pre_en = wdt_tick_in;
    else if (mode_r.src_ext) pre_en = pin_rise;
    else                     pre_en = cyc_tick;
  end

  spt_prescaler #(.RATE_W(RATE_W)) u_pre (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .clr       (pre_clr),
    .en        (pre_en),
    .owner_wdt (mode_r.owner_wdt),
    .rate      (mode_r.rate),
    .pulse     (pre_pulse),
    .lvl       (pre_lvl)
  );

  always_comb begin
    strobe  = phase_q[PH_A] | phase_q[PH_B];
    sel_lvl = mode_r.owner_wdt ? pin_lvl : pre_lvl;
    smp_n   = strobe ? sel_lvl : smp_r;
    ext_inc = strobe & sel_lvl & ~smp_r;
    int_inc = mode_r.owner_wdt ? cyc_tick : pre_pulse;
    tmr_inc = mode_r.src_ext ? ext_inc : int_inc;
    wdt_n   = mode_r.owner_wdt ? pre_pulse : wdt_tick_in;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      mode_r <= MODE_RST;
      smp_r  <= 1'b0;
      wdt_r  <= 1'b0;
    end else begin
      mode_r <= mode_n;
      smp_r  <= smp_n;
      wdt_r  <= wdt_n;
    end
  end

  assign wdt_tick_out = wdt_r;

  spt_count8 #(.W(CNT_W), .INH(INH_CYC)) u_cnt (
    .clk   (clk),
    .rst_n (rst_int_n),
    .we    (cnt_we),
    .wdata (cnt_wdata),
    .inc   (tmr_inc),
    .tick  (cyc_tick),
    .q     (cnt_q),
    .ovf   (ovf_flag)
  );

  AST_SAMPLE_ONLY: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!$past(cnt_we) && (cnt_q != $past(cnt_q))) |-> $past(strobe)); // R11
  AST_WDT_BYPASS: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!mode_r.owner_wdt && wdt_tick_in) |=> wdt_tick_out); // R5
  AST_WDT_QUIET: assert property (@(posedge clk) disable iff (!rst_int_n)
    !wdt_tick_in |=> !wdt_tick_out); // R5
endmodule

// File: tb/sim_spt_timer_top.sv
module sim_spt_timer_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_we = 1'b0;
  logic [5:0] mode_wdata = '0;
  logic       cnt_we = 1'b0;
  logic [7:0] cnt_wdata = '0;
  logic [7:0] cnt_q;
  logic       ovf_flag;
  logic       ext_pin = 1'b1;
  logic       wdt_tick_in = 1'b0;
  logic       wdt_tick_out;
  logic [3:0] phase_q;

  int checks = 0;
  int fails = 0;
  int r11_viol = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spt_timer_top u0 (
    .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_wdata(mode_wdata),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .cnt_q(cnt_q), .ovf_flag(ovf_flag),
    .ext_pin(ext_pin), .wdt_tick_in(wdt_tick_in), .wdt_tick_out(wdt_tick_out),
    .phase_q(phase_q)
  );

  // R11 watcher: values before each edge, compared at the following negedge
  logic [3:0] w_ph;
  logic       w_we;
  logic [7:0] w_cnt;
  always @(posedge clk) begin
    w_ph  <= phase_q;
    w_we  <= cnt_we;
    w_cnt <= cnt_q;
  end
  always @(negedge clk) begin
    if (rst_n && (cnt_q != w_cnt) && !w_we && !(w_ph[1] | w_ph[3]))
      r11_viol++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_mode(input bit src, input bit edg, input bit own, input int rate);
    @(negedge clk);
    mode_we = 1'b1;
    mode_wdata = {src, edg, own, 3'(rate)};
    @(negedge clk);
    mode_we = 1'b0;
  endtask

  task automatic wr_cnt(input logic [7:0] v);
    @(negedge clk);
    cnt_we = 1'b1;
    cnt_wdata = v;
    @(negedge clk);
    cnt_we = 1'b0;
  endtask

  task automatic run_ticks(input int n);
    int seen = 0;
    while (seen < n) begin
      if (phase_q[3]) seen++;
      @(negedge clk);
    end
  endtask

  task automatic pulses(input bit edg, input int n);
    for (int i = 0; i < n; i++) begin
      ext_pin = ~edg;
      cyc(3);
      ext_pin = edg;
      cyc(3);
    end
    cyc(12);
  endtask

  task automatic wdt_run(input int n, output int got);
    got = 0;
    for (int i = 0; i < 2*n + 4; i++) begin
      if (wdt_tick_out) got++;
      wdt_tick_in = (i < 2*n) && (i % 2 == 0);
      @(negedge clk);
    end
    wdt_tick_in = 1'b0;
  endtask

  function automatic int exp_int(input int n, input bit own, input int rate);
    int d = own ? 1 : (2 << rate);
    int skip = 0;
    for (int t = 1; t <= 2 && t <= n; t++) if (t % d == 0) skip++;
    return n / d - skip;
  endfunction

  function automatic int exp_ext(input int e, input bit own, input int rate);
    return own ? e : e / (2 << rate);
  endfunction

  task automatic ext_case(input bit edg, input bit own, input int rate,
                          input logic [7:0] start, input int e, input string req);
    int inc;
    wr_mode(1'b1, edg, own, rate);
    ext_pin = edg;
    cyc(12);
    wr_cnt(start);
    cyc(16);
    pulses(edg, e);
    inc = exp_ext(e, own, rate);
    chk(req, cnt_q, (int'(start) + inc) % 256);
    chk("R8", ovf_flag, (int'(start) + inc) > 255);
  endtask

  task automatic int_case(input bit own, input int rate, input logic [7:0] start,
                          input int n, input string req);
    int inc;
    wr_mode(1'b0, 1'b0, own, rate);
    wr_cnt(start);
    run_ticks(n);
    inc = exp_int(n, own, rate);
    chk(req, cnt_q, (int'(start) + inc) % 256);
    chk("R8", ovf_flag, (int'(start) + inc) > 255);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int got;
    int first;
    void'($urandom(32'h5EED_1234));
    cyc(3);
    rst_n = 1'b1;
    cyc(4);

    // R1: reset state
    chk("R1 cnt", cnt_q, 0);
    chk("R1 ovf", ovf_flag, 0);
    chk("R1 wdt", wdt_tick_out, 0);
    // R1 / R6 / R7: default = external, falling edge, pass-through
    pulses(1'b1, 5);
    chk("R1 R6 falling default", cnt_q, 5);
    // R1 / R5: default watchdog rate 128
    wdt_run(127, got);
    chk("R1 R5 wdt 127", got, 0);
    wdt_run(1, got);
    chk("R1 R5 wdt 128th", got, 1);

    // R2: phase rotation
    first = 0;
    for (int k = 0; k < 4; k++) if (phase_q[k]) first = k;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      chk("R2 phase", phase_q, 4'b0001 << ((first + k) % 4));
    end

    // R3: internal, no prescaler
    int_case(1'b1, 0, 8'h00, 10, "R3");
    chk("R3 value", cnt_q, 8);

    // R9: two-tick blackout after write
    wr_cnt(8'h40);
    run_ticks(2);
    chk("R9 blackout", cnt_q, 8'h40);
    run_ticks(1);
    chk("R9 first inc", cnt_q, 8'h41);

    // R8: wrap and sticky flag
    wr_cnt(8'hFD);
    run_ticks(5);
    chk("R8 wrap cnt", cnt_q, 0);
    chk("R8 wrap ovf", ovf_flag, 1);
    run_ticks(4);
    chk("R8 sticky cnt", cnt_q, 4);
    chk("R8 sticky ovf", ovf_flag, 1);
    wr_cnt(8'h07);
    chk("R9 load", cnt_q, 8'h07);
    chk("R9 ovf clear", ovf_flag, 0);

    // R4: timer divide by 4 and by 2
    int_case(1'b0, 1, 8'h00, 40, "R4 div4");
    int_case(1'b0, 0, 8'h10, 20, "R4 div2");

    // R10: rate change mid-count restarts the prescaler
    wr_mode(1'b0, 1'b0, 1'b0, 3);
    wr_cnt(8'h00);
    run_ticks(10);
    chk("R10 before", cnt_q, 0);
    wr_mode(1'b0, 1'b0, 1'b0, 2);
    run_ticks(7);
    chk("R10 no early tick", cnt_q, 0);
    run_ticks(1);
    chk("R10 full period", cnt_q, 1);

    // R6 / R7: rising edge pass-through, falling edge prescaled
    ext_case(1'b0, 1'b1, 4, 8'h20, 6, "R6 R7 rising");
    ext_case(1'b1, 1'b0, 0, 8'h00, 9, "R6 R4 falling div2");

    // R5: bypass and watchdog prescaling
    wr_mode(1'b0, 1'b0, 1'b0, 5);
    wdt_run(9, got);
    chk("R5 bypass", got, 9);
    wr_mode(1'b0, 1'b0, 1'b1, 2);
    wdt_run(13, got);
    chk("R5 div4", got, 3);
    wr_mode(1'b0, 1'b0, 1'b1, 0);
    wdt_run(5, got);
    chk("R5 div1", got, 5);

    // random mix
    for (int it = 0; it < 24; it++) begin
      bit own = 1'($urandom);
      int rate = $urandom % 8;
      logic [7:0] start = 8'($urandom);
      if (it % 4 == 3) start = 8'hF8 + 8'($urandom % 8);
      if (it % 2 == 0)
        int_case(own, rate, start, 8 + $urandom % 400, own ? "R3 rand" : "R4 rand");
      else
        ext_case(1'($urandom), own, rate, start, 1 + $urandom % 60,
                 own ? "R7 rand" : "R4 ext rand");
    end

    chk("R11 sample points", r11_viol, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule